// File: doc/BRIEF.md
# Operand Forwarding and Load-Use Stall Unit

This block holds the data-hazard decisions of a five-stage in-order integer pipeline (fetch, decode, execute, memory, write-back). Each cycle it compares the source register numbers of the instruction in execute against the destination numbers held in the execute/memory and memory/write-back pipeline registers. From that comparison it drives the select lines of three multiplexers: the first ALU operand, the second ALU operand, and the store-data path. The register file, ALU, memories and pipeline registers sit outside the block. Only their register numbers and control bits reach it.

It also compares the sources of the instruction in decode against the destination of a load in execute. A load's data is not ready in time to be forwarded to the very next instruction. In that case the block raises a stall, which holds the PC and the fetch/decode register, and a bubble, which turns the decode/execute register into a no-op for one cycle.

A producer three instructions ahead needs no path. The register file writes in the first half of a cycle and reads in the second, so that value arrives through the normal register read. The unit is purely combinational and has no state.

Top module: `hazard_fwd_unit`

## Requirements
- R1: A live execute-stage source that equals an execute/memory destination with write enable set and a nonzero number selects code 2'b10 (younger result) on its multiplexer.
- R2: A live source that matches only the memory/write-back destination (write enable set, nonzero) selects code 2'b01.
- R3: When both stages match the same source, code 2'b10 wins over 2'b01.
- R4: Register 0 never produces a forwarding match or a stall, on any path.
- R5: A stage whose write enable is clear, such as a store or a branch, is never a forwarding source.
- R6: When the second ALU operand is the immediate form (exUsesRs2Reg=0), selB is 2'b00 whatever the register numbers are.
- R7: The store-data select applies the same matching and priority to the second source number when exIsStore=1, and it is 2'b00 when exIsStore=0. This holds independently of the second ALU input's form.
- R8: A load-use stall is raised when the execute instruction is a load (exMemRead=1, exRegWrite=1, nonzero exRd) and a decode source in use (idUsesRs1/idUsesRs2) equals exRd. In that case stall=1 and bubble=1. Otherwise both are 0.
- R9: A source with no match, or one not in use (exUsesRs1=0), selects code 2'b00, the register file.
- R10: Forwarding selects and the load-use stall are decided independently, so both can be active in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| idRs1 | input | 5 | First source number of the decode instruction |
| idRs2 | input | 5 | Second source number of the decode instruction |
| idUsesRs1 | input | 1 | Decode instruction reads its first source |
| idUsesRs2 | input | 1 | Decode instruction reads its second source |
| exRs1 | input | 5 | First source number of the execute instruction |
| exRs2 | input | 5 | Second source number of the execute instruction |
| exUsesRs1 | input | 1 | Execute instruction reads its first source |
| exUsesRs2Reg | input | 1 | Second ALU operand is a register (0 = immediate) |
| exIsStore | input | 1 | Execute instruction is a store |
| exRd | input | 5 | Destination of the execute instruction |
| exRegWrite | input | 1 | Execute instruction writes a register |
| exMemRead | input | 1 | Execute instruction is a load |
| memRd | input | 5 | Destination held in execute/memory register |
| memRegWrite | input | 1 | Write enable held in execute/memory register |
| wbRd | input | 5 | Destination held in memory/write-back register |
| wbRegWrite | input | 1 | Write enable held in memory/write-back register |
| fwdSelA | output | 2 | First ALU operand select (00 RF, 01 MEM/WB, 10 EX/MEM) |
| fwdSelB | output | 2 | Second ALU operand select, same coding |
| fwdSelStore | output | 2 | Store-data select, same coding |
| stall | output | 1 | Hold PC and fetch/decode register |
| bubble | output | 1 | Insert a no-op into decode/execute register |

## Verification
A load-use stall and an execute-stage forward can occur in the same cycle. The stall comes from the decode instruction's dependence on a load in execute. The forward comes from the execute instruction's dependence on older results. The bench provokes this with one stimulus: a load in execute whose destination the decode instruction reads, while the execute instruction's first source matches the execute/memory destination. It then checks that the stall and bubble are raised and that selA still reads 2'b10. A mirror case sets a non-load producer with the same numbers and expects the forward without a stall.

// File: rtl/hz_pkg.sv
package hz_pkg;
  localparam int REG_ADDR_W = 5;
  localparam int NUM_SRC    = 3;
  localparam int SRC_A      = 0;
  localparam int SRC_B      = 1;
  localparam int SRC_ST     = 2;

  typedef enum logic [1:0] {
    SEL_RF  = 2'b00,
    SEL_WB  = 2'b01,
    SEL_MEM = 2'b10
  } fwdSel_e;

  // strobes from control to the forwarding datapath
  typedef struct packed {
    logic [NUM_SRC-1:0] srcLive;
    logic               stall;
    logic               bubble;
  } hzStrobe_t;
endpackage

// File: rtl/hz_src_match.sv
module hz_src_match
  import hz_pkg::*;
#(
  parameter int ADDR_W = REG_ADDR_W
) (
  input  logic [ADDR_W-1:0] srcReg,
  input  logic              srcLive,
  input  logic [ADDR_W-1:0] memRd,
  input  logic              memWrite,
  input  logic [ADDR_W-1:0] wbRd,
  input  logic              wbWrite,
  output fwdSel_e           sel
);
  logic memHit;
  logic wbHit;

  assign memHit = srcLive && memWrite && (memRd != '0) && (memRd == srcReg);
  assign wbHit  = srcLive && wbWrite  && (wbRd  != '0) && (wbRd  == srcReg);

  always_comb begin
    if (memHit)     sel = SEL_MEM;
    else if (wbHit) sel = SEL_WB;
    else            sel = SEL_RF;
  end

  always_comb begin
    if (!$isunknown({srcReg, srcLive, memRd, memWrite, wbRd, wbWrite})) begin
      AST_NO_ZERO_FWD: assert (sel == SEL_RF || srcReg != '0) else $error("zero forwarded"); // R4
      AST_MEM_NEEDS_WRITE: assert (sel != SEL_MEM || memWrite) else $error("mem src no write"); // R5
      AST_WB_NEEDS_WRITE: assert (sel != SEL_WB || (wbWrite && !(memWrite && memRd == srcReg))) else $error("wb sel bad"); // R3
      AST_DEAD_SRC_RF: assert (srcLive || sel == SEL_RF) else $error("dead src forwarded"); // R9
    end
  end
endmodule

// File: rtl/hz_stall_ctrl.sv
module hz_stall_ctrl
  import hz_pkg::*;
#(
  parameter int ADDR_W = REG_ADDR_W
) (
  input  logic [ADDR_W-1:0] idRs1,
  input  logic [ADDR_W-1:0] idRs2,
  input  logic              idUsesRs1,
  input  logic              idUsesRs2,
  input  logic [ADDR_W-1:0] exRd,
  input  logic              exRegWrite,
  input  logic              exMemRead,
  input  logic              exUsesRs1,
  input  logic              exUsesRs2Reg,
  input  logic              exIsStore,
  output hzStrobe_t         strobe
);
  logic loadInEx;
  logic useHit;

  assign loadInEx = exMemRead && exRegWrite && (exRd != '0);
  assign useHit   = (idUsesRs1 && idRs1 == exRd) || (idUsesRs2 && idRs2 == exRd);

  always_comb begin
    strobe                 = '0;
    strobe.srcLive[SRC_A]  = exUsesRs1;
    strobe.srcLive[SRC_B]  = exUsesRs2Reg;
    strobe.srcLive[SRC_ST] = exIsStore;
    strobe.stall           = loadInEx && useHit;
    strobe.bubble          = loadInEx && useHit;
  end

  always_comb begin
    if (!$isunknown({idRs1, idRs2, idUsesRs1, idUsesRs2, exRd, exRegWrite, exMemRead})) begin
      AST_STALL_NEEDS_LOAD: assert (!strobe.stall || exMemRead) else $error("stall w/o load"); // R8
      AST_STALL_NOT_R0: assert (!strobe.stall || exRd != '0) else $error("stall on r0"); // R4
      AST_STALL_NEEDS_USE: assert (!strobe.stall || idUsesRs1 || idUsesRs2) else $error("stall w/o use"); // R8
    end
  end
endmodule

// File: rtl/hz_fwd_path.sv
module hz_fwd_path
  import hz_pkg::*;
#(
  parameter int ADDR_W = REG_ADDR_W,
  parameter int N_SRC  = NUM_SRC
) (
  input  logic [N_SRC-1:0][ADDR_W-1:0] srcRegs,
  input  hzStrobe_t                    strobe,
  input  logic [ADDR_W-1:0]            memRd,
  input  logic                         memRegWrite,
  input  logic [ADDR_W-1:0]            wbRd,
  input  logic                         wbRegWrite,
  output logic [N_SRC-1:0][1:0]        selOut
);
  fwdSel_e selVec [N_SRC];

  for (genvar g = 0; g < N_SRC; g++) begin : g_src
    hz_src_match #(.ADDR_W(ADDR_W)) u_match (
      .srcReg  (srcRegs[g]),
      .srcLive (strobe.srcLive[g]),
      .memRd   (memRd),
      .memWrite(memRegWrite),
      .wbRd    (wbRd),
      .wbWrite (wbRegWrite),
      .sel     (selVec[g])
    );
    assign selOut[g] = selVec[g];
  end

  always_comb begin
    if (!$isunknown({srcRegs, strobe, memRd, memRegWrite, wbRd, wbRegWrite})) begin
      AST_IMM_NO_FWD: assert (strobe.srcLive[SRC_B] || selOut[SRC_B] == SEL_RF) else $error("imm forwarded"); // R6
      AST_STORE_OFF: assert (strobe.srcLive[SRC_ST] || selOut[SRC_ST] == SEL_RF) else $error("store sel w/o store"); // R7
      AST_SEL_LEGAL: assert (selOut[SRC_A] != 2'b11 && selOut[SRC_B] != 2'b11) else $error("illegal sel"); // R1
    end
  end
endmodule

// File: rtl/hazard_fwd_unit.sv
module hazard_fwd_unit
  import hz_pkg::*;
(
  input  logic [4:0] idRs1,
  input  logic [4:0] idRs2,
  input  logic       idUsesRs1,
  input  logic       idUsesRs2,
  input  logic [4:0] exRs1,
  input  logic [4:0] exRs2,
  input  logic       exUsesRs1,
  input  logic       exUsesRs2Reg,
  input  logic       exIsStore,
  input  logic [4:0] exRd,
  input  logic       exRegWrite,
  input  logic       exMemRead,
  input  logic [4:0] memRd,
  input  logic       memRegWrite,
  input  logic [4:0] wbRd,
  input  logic       wbRegWrite,
  output logic [1:0] fwdSelA,
  output logic [1:0] fwdSelB,
  output logic [1:0] fwdSelStore,
  output logic       stall,
  output logic       bubble
);
  hzStrobe_t                            strobe;
  logic [NUM_SRC-1:0][REG_ADDR_W-1:0]   srcRegs;
  logic [NUM_SRC-1:0][1:0]              sels;

  always_comb begin
    srcRegs         = '0;
    srcRegs[SRC_A]  = exRs1;
    srcRegs[SRC_B]  = exRs2;
    srcRegs[SRC_ST] = exRs2;
  end

  hz_stall_ctrl #(.ADDR_W(REG_ADDR_W)) u_ctrl (
    .idRs1       (idRs1),
    .idRs2       (idRs2),
    .idUsesRs1   (idUsesRs1),
    .idUsesRs2   (idUsesRs2),
    .exRd        (exRd),
    .exRegWrite  (exRegWrite),
    .exMemRead   (exMemRead),
    .exUsesRs1   (exUsesRs1),
    .exUsesRs2Reg(exUsesRs2Reg),
    .exIsStore   (exIsStore),
    .strobe      (strobe)
  );

  hz_fwd_path #(.ADDR_W(REG_ADDR_W), .N_SRC(NUM_SRC)) u_path (
    .srcRegs    (srcRegs),
    .strobe     (strobe),
    .memRd      (memRd),
    .memRegWrite(memRegWrite),
    .wbRd       (wbRd),
    .wbRegWrite (wbRegWrite),
    .selOut     (sels)
  );

  assign fwdSelA     = sels[SRC_A];
  assign fwdSelB     = sels[SRC_B];
  assign fwdSelStore = sels[SRC_ST];
  assign stall       = strobe.stall;
  assign bubble      = strobe.bubble;
endmodule

// File: tb/sim_hazard_fwd_unit.sv
module sim_hazard_fwd_unit;
  logic clk = 1'b0;
  always #10 clk = ~clk; // 50 MHz

  logic [4:0] idRs1, idRs2, exRs1, exRs2, exRd, memRd, wbRd;
  logic idUsesRs1, idUsesRs2, exUsesRs1, exUsesRs2Reg, exIsStore;
  logic exRegWrite, exMemRead, memRegWrite, wbRegWrite;
  logic [1:0] fwdSelA, fwdSelB, fwdSelStore;
  logic stall, bubble;

  int checks = 0;
  int failures = 0;
  logic finished = 1'b0;

  hazard_fwd_unit u0 (.*);

  typedef struct packed {
    logic [4:0] rs1; logic [4:0] rs2;
    logic u1; logic u2r; logic st;
    logic [4:0] mRd; logic mW;
    logic [4:0] wRd; logic wW;
    logic [1:0] eA; logic [1:0] eB; logic [1:0] eS;
  } fvec_t;

  localparam int NV = 12;
  localparam fvec_t VEC [NV] = '{
    '{5'd3,  5'd4,  1'b1,1'b1,1'b0, 5'd3,  1'b1, 5'd9,  1'b1, 2'b10,2'b00,2'b00}, // R1
    '{5'd5,  5'd6,  1'b1,1'b1,1'b0, 5'd6,  1'b1, 5'd0,  1'b0, 2'b00,2'b10,2'b00}, // R1
    '{5'd7,  5'd8,  1'b1,1'b1,1'b0, 5'd1,  1'b1, 5'd7,  1'b1, 2'b01,2'b00,2'b00}, // R2
    '{5'd10, 5'd10, 1'b1,1'b1,1'b0, 5'd10, 1'b1, 5'd10, 1'b1, 2'b10,2'b10,2'b00}, // R3
    '{5'd0,  5'd0,  1'b1,1'b1,1'b0, 5'd0,  1'b1, 5'd0,  1'b1, 2'b00,2'b00,2'b00}, // R4
    '{5'd11, 5'd12, 1'b1,1'b1,1'b0, 5'd11, 1'b0, 5'd12, 1'b0, 2'b00,2'b00,2'b00}, // R5
    '{5'd13, 5'd13, 1'b1,1'b0,1'b0, 5'd13, 1'b1, 5'd2,  1'b1, 2'b10,2'b00,2'b00}, // R6
    '{5'd14, 5'd15, 1'b1,1'b0,1'b1, 5'd1,  1'b1, 5'd15, 1'b1, 2'b00,2'b00,2'b01}, // R7
    '{5'd16, 5'd17, 1'b1,1'b0,1'b1, 5'd17, 1'b1, 5'd17, 1'b1, 2'b00,2'b00,2'b10}, // R7
    '{5'd18, 5'd19, 1'b1,1'b1,1'b0, 5'd20, 1'b1, 5'd21, 1'b1, 2'b00,2'b00,2'b00}, // R9
    '{5'd22, 5'd23, 1'b1,1'b1,1'b0, 5'd23, 1'b1, 5'd5,  1'b1, 2'b00,2'b10,2'b00}, // R7
    '{5'd24, 5'd25, 1'b0,1'b1,1'b0, 5'd24, 1'b1, 5'd25, 1'b1, 2'b00,2'b01,2'b00}  // R9
  };

  task automatic check(input string req, input logic [1:0] act, input logic [1:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic idle();
    idRs1 = 0; idRs2 = 0; idUsesRs1 = 0; idUsesRs2 = 0;
    exRs1 = 0; exRs2 = 0; exUsesRs1 = 0; exUsesRs2Reg = 0; exIsStore = 0;
    exRd = 0; exRegWrite = 0; exMemRead = 0;
    memRd = 0; memRegWrite = 0; wbRd = 0; wbRegWrite = 0;
  endtask

  task automatic settle();
    @(negedge clk);
    #2;
  endtask

  task automatic setLoad(input logic [4:0] rd, input logic [4:0] a, input logic [4:0] b,
                         input logic ua, input logic ub);
    exRd = rd; exRegWrite = 1; exMemRead = 1;
    idRs1 = a; idRs2 = b; idUsesRs1 = ua; idUsesRs2 = ub;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      checks++; failures++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    idle();
    settle();
    // reset / idle state
    check("R9 idle selA", fwdSelA, 2'b00);
    check("R9 idle selB", fwdSelB, 2'b00);
    check("R7 idle selStore", fwdSelStore, 2'b00);
    check("R8 idle stall", {1'b0, stall}, 2'b00);

    for (int i = 0; i < NV; i++) begin
      idle();
      exRs1 = VEC[i].rs1; exRs2 = VEC[i].rs2;
      exUsesRs1 = VEC[i].u1; exUsesRs2Reg = VEC[i].u2r; exIsStore = VEC[i].st;
      memRd = VEC[i].mRd; memRegWrite = VEC[i].mW;
      wbRd = VEC[i].wRd; wbRegWrite = VEC[i].wW;
      settle();
      check($sformatf("vec%0d selA R1/R2/R3", i), fwdSelA, VEC[i].eA);
      check($sformatf("vec%0d selB R6", i), fwdSelB, VEC[i].eB);
      check($sformatf("vec%0d selStore R7", i), fwdSelStore, VEC[i].eS);
      check($sformatf("vec%0d no stall R8", i), {1'b0, stall}, 2'b00);
    end

    // R8 load-use on first source
    idle(); setLoad(5'd6, 5'd6, 5'd1, 1, 1); settle();
    check("R8 stall rs1", {1'b0, stall}, 2'b01);
    check("R8 bubble rs1", {1'b0, bubble}, 2'b01);
    // R8 load-use on second source (e.g. following store data)
    idle(); setLoad(5'd9, 5'd2, 5'd9, 1, 1); settle();
    check("R8 stall rs2", {1'b0, stall}, 2'b01);
    // R8 source matched but not in use
    idle(); setLoad(5'd9, 5'd9, 5'd9, 0, 0); settle();
    check("R8 unused no stall", {1'b0, stall}, 2'b00);
    // R8 non-load producer: no stall
    idle(); setLoad(5'd6, 5'd6, 5'd6, 1, 1); exMemRead = 0; settle();
    check("R8 alu producer no stall", {1'b0, bubble}, 2'b00);
    // R4 load to register 0
    idle(); setLoad(5'd0, 5'd0, 5'd0, 1, 1); settle();
    check("R4 r0 load no stall", {1'b0, stall}, 2'b00);
    // R10 stall and forward in same cycle
    idle(); setLoad(5'd12, 5'd12, 5'd3, 1, 1);
    exRs1 = 5'd4; exUsesRs1 = 1; memRd = 5'd4; memRegWrite = 1; settle();
    check("R10 stall with fwd", {1'b0, stall}, 2'b01);
    check("R10 bubble with fwd", {1'b0, bubble}, 2'b01);
    check("R10 selA with stall", fwdSelA, 2'b10);
    // R10 mirror: same numbers, non-load producer
    exMemRead = 0; settle();
    check("R10 fwd no stall", {1'b0, stall}, 2'b00);
    check("R10 selA kept", fwdSelA, 2'b10);
    // R5 store in EX/MEM (write enable clear) falls back to MEM/WB
    idle(); exRs1 = 5'd8; exUsesRs1 = 1; memRd = 5'd8; memRegWrite = 0;
    wbRd = 5'd8; wbRegWrite = 1; settle();
    check("R5 skip non-writer", fwdSelA, 2'b01);

    finished = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule